// File: doc/BRIEF.md
# Addressed Serial Eight-Channel DAC Code Front End

This block is the digital side of an eight-channel digital-to-analog converter that is programmed over a three-wire serial port. A 16-bit word is clocked in one bit per shift-clock edge, most significant bit first. Each word carries a 4-bit device address, a 4-bit channel address and an 8-bit converter code. When the active-low load strobe falls, the device address is compared with four strap inputs. On a match, the code is written into the holding register of the addressed channel. Those registers drive the eight converters.

Several devices can share one data line and one load line. The serial output passes on the bit that falls off the top of the shift register. Its output enable is released while the load strobe is active, so the chained outputs can be wired together. While the strobe is held, shifting is frozen. A reset puts every channel back at mid-scale.

Top module: `octal_dac_front`

## Requirements
- R1: A synchronous active-high reset sets all eight channel codes to 8'h80, drives `ser_out` low and sets `ser_oe` to 1.
- R2: On every rising clock edge where `load_n` is high, the shift register moves up one place and takes `ser_in` into bit 0. Bits [15:12] of the word are the device address, bits [11:8] the channel address and bits [7:0] the code.
- R3: On a clock edge where `load_n` is low, the shift register and `ser_out` keep their values. Bits presented on `ser_in` during the strobe are lost.
- R4: On the first clock edge where `load_n` is sampled low after being high, a channel is updated if the device address equals `strap` on all four bits and the channel address is 0 to 7. That channel's code becomes bits [7:0] of the word, visible after that edge.
- R5: If the device address differs from `strap` in any bit, the strobe changes no channel code.
- R6: A channel address from 8 to 15 changes no channel code.
- R7: A strobe changes at most one channel. Every other channel keeps its code.
- R8: Exactly one update is made per strobe. The match is decided at the falling edge, so a `strap` change while `load_n` stays low causes no write.
- R9: After each shifting edge, `ser_out` shows the bit that was in position 15 before that edge.
- R10: `ser_oe` is the registered level of `load_n`: 0 (output released) in the cycle after `load_n` is sampled low, and 1 again in the cycle after it is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset to mid-scale |
| ser_in | input | 1 | Serial word input, MSB first |
| load_n | input | 1 | Active-low load strobe; freezes shifting while low |
| strap | input | 4 | Device address straps, bit 0 least significant |
| ser_out | output | 1 | Chained serial output (bit leaving position 15) |
| ser_oe | output | 1 | Drive enable for the serial output buffer; 0 means high impedance |
| codes | output | 64 | Channel codes; channel i occupies bits [8i+7:8i] |

## Verification
The bench drives addresses that differ from the straps by a single bit and expects no write; a comparator that checks only some of the bits would write a channel anyway. It uses channel addresses 8 and 15, where a decoder that ignores the top address bit would write channel 0 or channel 7. It toggles `ser_in` during a long strobe and then checks that the next word pushes out the earlier one bit for bit; a design that keeps shifting during the strobe would put a skewed sequence on `ser_out`. It also changes the straps to a matching value in the middle of a strobe, which a level-sensitive load would turn into a late write. It resets after channels have been loaded and expects every code back at 8'h80.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
    localparam int CHIP_W = 4;
    localparam int CHAN_W = 4;
    localparam int CODE_W = 8;
    localparam int NUM_CH = 8;
    localparam int WORD_W = CHIP_W + CHAN_W + CODE_W;
    localparam int BANK_W = NUM_CH * CODE_W;

    typedef struct packed {
        logic [CHIP_W-1:0] chip;
        logic [CHAN_W-1:0] chan;
        logic [CODE_W-1:0] code;
    } word_t;

    function automatic logic [CODE_W-1:0] mid_code();
        logic [CODE_W-1:0] m;
        m = '0;
        m[CODE_W-1] = 1'b1;
        return m;
    endfunction

    function automatic logic [NUM_CH-1:0] chan_onehot(input logic [CHAN_W-1:0] a);
        logic [NUM_CH-1:0] v;
        v = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (a == CHAN_W'(i)) v[i] = 1'b1;
        end
        return v;
    endfunction
endpackage

// File: rtl/sdac_shift_port.sv
module sdac_shift_port
    import sdac_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ser_in,
    input  logic  load_n,
    output word_t word,
    output logic  ser_out,
    output logic  ser_oe,
    output logic  strobe_fall
);
    logic [WORD_W-1:0] sreg;
    logic              out_bit;
    logic              load_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg    <= '0;
            out_bit <= 1'b0;
            load_q  <= 1'b1;
        end else begin
            load_q <= load_n;
            if (load_n) begin
                sreg    <= {sreg[WORD_W-2:0], ser_in};
                out_bit <= sreg[WORD_W-1];
            end
        end
    end

    assign word        = word_t'(sreg);
    assign ser_out     = out_bit;
    assign ser_oe      = load_q;
    assign strobe_fall = load_q & ~load_n;
endmodule

// File: rtl/sdac_addr_match.sv
module sdac_addr_match
    import sdac_pkg::*;
(
    input  word_t             word,
    input  logic [CHIP_W-1:0] strap,
    input  logic              strobe_fall,
    output logic [NUM_CH-1:0] wr_en
);
    logic hit;

    always_comb begin
        hit   = strobe_fall && (word.chip == strap);
        wr_en = hit ? chan_onehot(word.chan) : '0;
    end
endmodule

// File: rtl/sdac_chan_bank.sv
module sdac_chan_bank
    import sdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] wr_en,
    input  logic [CODE_W-1:0] din,
    output logic [BANK_W-1:0] codes
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic [CODE_W-1:0] hold;
        always_ff @(posedge clk) begin
            if (rst)           hold <= mid_code();
            else if (wr_en[g]) hold <= din;
        end
        assign codes[g*CODE_W +: CODE_W] = hold;
    end
endmodule

// File: rtl/octal_dac_front.sv
module octal_dac_front
    import sdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_in,
    input  logic              load_n,
    input  logic [CHIP_W-1:0] strap,
    output logic              ser_out,
    output logic              ser_oe,
    output logic [BANK_W-1:0] codes
);
    word_t             word;
    logic              strobe_fall;
    logic [NUM_CH-1:0] wr_en;

    sdac_shift_port u_shift (
        .clk(clk), .rst(rst), .ser_in(ser_in), .load_n(load_n),
        .word(word), .ser_out(ser_out), .ser_oe(ser_oe),
        .strobe_fall(strobe_fall)
    );

    sdac_addr_match u_match (
        .word(word), .strap(strap), .strobe_fall(strobe_fall), .wr_en(wr_en)
    );

    sdac_chan_bank u_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .din(word.code), .codes(codes)
    );
endmodule

// File: rtl/octal_dac_front_chk.sv
module octal_dac_front_chk
    import sdac_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              load_n,
    input logic [CHIP_W-1:0] strap,
    input logic              ser_out,
    input logic              ser_oe,
    input logic [BANK_W-1:0] codes,
    input logic [WORD_W-1:0] sreg
);
    logic              prev_n;
    logic [BANK_W-1:0] codes_q;
    logic [NUM_CH-1:0] chg;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_n  <= 1'b1;
            codes_q <= {NUM_CH{mid_code()}};
        end else begin
            prev_n  <= load_n;
            codes_q <= codes;
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_CH; i++)
            chg[i] = codes[i*CODE_W +: CODE_W] != codes_q[i*CODE_W +: CODE_W];
    end

    AST_RESET_MID: assert property (@(posedge clk) rst |=> (codes == {NUM_CH{mid_code()}})); // R1
    AST_FROZEN_OUT: assert property (@(posedge clk) disable iff (rst) !load_n |=> $stable(ser_out)); // R3
    AST_OE_OFF: assert property (@(posedge clk) disable iff (rst) !load_n |=> !ser_oe); // R10
    AST_OE_ON: assert property (@(posedge clk) disable iff (rst) load_n |=> ser_oe); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) load_n |=> $stable(codes)); // R4
    AST_ONE_WRITE: assert property (@(posedge clk) disable iff (rst) (!load_n && !prev_n) |=> $stable(codes)); // R8
    AST_FOREIGN_CHIP: assert property (@(posedge clk) disable iff (rst)
        (!load_n && prev_n && (sreg[WORD_W-1 -: CHIP_W] != strap)) |=> $stable(codes)); // R5
    AST_BAD_CHAN: assert property (@(posedge clk) disable iff (rst)
        (!load_n && prev_n && sreg[CODE_W+CHAN_W-1]) |=> $stable(codes)); // R6
    AST_SINGLE_CH: assert property (@(posedge clk) disable iff (rst) $countones(chg) <= 1); // R7
endmodule

bind octal_dac_front octal_dac_front_chk u_chk (
    .clk(clk), .rst(rst), .load_n(load_n), .strap(strap),
    .ser_out(ser_out), .ser_oe(ser_oe), .codes(codes),
    .sreg(u_shift.sreg)
);

// File: tb/octal_dac_front_tb.sv
module octal_dac_front_tb;
    import sdac_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst, ser_in, load_n, ser_out, ser_oe;
    logic [3:0]  strap;
    logic [63:0] codes;

    octal_dac_front u_dut (
        .clk(clk), .rst(rst), .ser_in(ser_in), .load_n(load_n), .strap(strap),
        .ser_out(ser_out), .ser_oe(ser_oe), .codes(codes)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] m_sr;
    logic        m_out;
    logic [7:0]  m_code [8];

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_codes();
        logic [63:0] v;
        for (int i = 0; i < 8; i++) v[i*8 +: 8] = m_code[i];
        return v;
    endfunction

    function automatic logic [15:0] mk(input logic [3:0] c, input logic [3:0] ch, input logic [7:0] d);
        return {c, ch, d};
    endfunction

    task automatic step();
        @(posedge clk);
        #5;
    endtask

    task automatic shift_bit(input logic b);
        ser_in = b;
        load_n = 1'b1;
        step();
        m_out = m_sr[15];
        m_sr  = {m_sr[14:0], b};
        chk("R9 ser_out after shift", 64'(ser_out), 64'(m_out));
        chk("R10 ser_oe driven", 64'(ser_oe), 64'd1);
    endtask

    task automatic shift_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) shift_bit(w[i]);
    endtask

    task automatic strobe(input int hold, input string tag);
        load_n = 1'b0;
        step();
        if (m_sr[15:12] == strap && !m_sr[11]) m_code[m_sr[10:8]] = m_sr[7:0];
        chk(tag, codes, exp_codes());
        chk("R10 ser_oe released", 64'(ser_oe), 64'd0);
        for (int k = 1; k < hold; k++) begin
            ser_in = 1'($urandom);
            step();
            chk("R3 ser_out frozen", 64'(ser_out), 64'(m_out));
            chk("R8 no repeat write", codes, exp_codes());
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step();
        step();
        rst = 1'b0;
        m_sr = '0;
        m_out = 1'b0;
        for (int i = 0; i < 8; i++) m_code[i] = 8'h80;
        chk("R1 codes mid-scale", codes, exp_codes());
        chk("R1 ser_out low", 64'(ser_out), 64'd0);
        chk("R1 ser_oe set", 64'(ser_oe), 64'd1);
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; ser_in = 1'b0; load_n = 1'b1; strap = 4'hA;
        do_reset();

        // R2 R4: field layout, matching device writes channel 6
        shift_word(mk(4'hA, 4'h6, 8'h3C));
        strobe(2, "R2 R4 write ch6");
        // R7: each channel gets its own code, others untouched
        for (int c = 0; c < 8; c++) begin
            shift_word(mk(4'hA, 4'(c), 8'(8'h11 * (c + 1))));
            strobe(1, "R7 per-channel write");
        end
        // R5: single-bit address mismatches
        for (int b = 0; b < 4; b++) begin
            shift_word(mk(4'hA ^ (4'h1 << b), 4'h2, 8'hE7));
            strobe(1, "R5 foreign device");
        end
        // R6: out-of-range channel addresses
        shift_word(mk(4'hA, 4'h8, 8'h01));
        strobe(1, "R6 chan 8");
        shift_word(mk(4'hA, 4'hF, 8'hFE));
        strobe(1, "R6 chan 15");
        // R3: long strobe with noise, then the next word pushes the old one out
        shift_word(mk(4'hA, 4'h3, 8'h96));
        strobe(20, "R3 R4 write before noise");
        shift_word(mk(4'h5, 4'h0, 8'h00));
        strobe(1, "R3 follow-up word");
        // R8: straps change to a match in mid-strobe
        shift_word(mk(4'h3, 4'h0, 8'h5A));
        load_n = 1'b0;
        step();
        chk("R8 mismatch at fall", codes, exp_codes());
        strap = 4'h3;
        for (int k = 0; k < 5; k++) begin
            step();
            chk("R8 late strap match ignored", codes, exp_codes());
        end
        strap = 4'hA;
        // R1: reset after loads
        do_reset();

        // random mix
        for (int n = 0; n < 300; n++) begin
            logic [3:0] c;
            if (($urandom % 10) == 0) strap = 4'($urandom);
            c = (($urandom % 10) < 7) ? strap : 4'($urandom);
            shift_word(mk(c, 4'($urandom), 8'($urandom)));
            strobe(1 + int'($urandom % 4), "R4 R5 R6 random load");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule